// File: doc/BRIEF.md
# Pipelined CORDIC Givens Rotator

This block performs one Givens rotation on fixed-point data. It uses only shifts and additions and accepts a new operand pair on every clock. In vectoring mode it takes a pair (x, y), turns it until y reaches zero, and returns the gain-corrected magnitude r in x. It also emits the sequence of decisions it made along the way as a direction word. In rotation mode it takes such a direction word together with another pair (x, y) from the same two matrix rows. It replays the identical sequence of micro-rotations on that pair. The pair is therefore turned through the same angle, and no angle, sine or cosine value is ever formed.

Each micro-rotation is its own register stage. A first stage folds operands with a negative x into the right half-plane by a quarter turn. A last stage multiplies both results by the constant CORDIC gain correction, built from a short shift-add sum, and rounds away the guard bits. A valid flag travels with every pair. Results appear exactly ITER+2 cycles after their inputs, in the same order.

Top module: `cordic_givens`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, out_valid is low.
- R2: Every input cycle with in_valid high yields exactly one output cycle with out_valid high, in input order, including when idle cycles are interleaved.
- R3: In vectoring mode (in_rotate = 0), out_x is non-negative and lies within 3 LSB of sqrt(x² + y²). This is checked for W = 16, ITER = 12 and inputs of magnitude up to about 20300.
- R4: In vectoring mode, out_y lies within ±(2^(W−ITER+1) + 4) of zero, which is ±36 at the default parameters.
- R5: Vectoring converges for every input quadrant, including x < 0 with either sign of y, by way of a quarter-turn pre-rotation.
- R6: The direction word has ITER+2 bits. Bit 0 is 1 exactly when the vectoring input had x < 0, which means a quarter turn was applied. Bit 1 holds the sign bit of the vectoring input y; when bit 0 is set, a value of 1 selects (x, y) → (−y, x) and a value of 0 selects (x, y) → (y, −x). Bit 2+i is 1 when micro-rotation i subtracted (x >>> i) from y.
- R7: In rotation mode (in_rotate = 1), in_dirs taken from vectoring the pair (a, b) turns a pair (c, d) into ((c·a + d·b)/r, (d·a − c·b)/r), where r = sqrt(a² + b²). Both results are within 24 LSB under the conditions of R3.
- R8: In rotation mode, out_dirs equals the in_dirs that entered with that pair.
- R9: The output for a pair appears exactly ITER+2 clock cycles after the cycle in which it was accepted.
- R10: In vectoring mode the value on in_dirs has no effect on out_x, out_y or out_dirs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the valid pipeline |
| in_valid | input | 1 | Input pair is present this cycle |
| in_rotate | input | 1 | 0 = vectoring, 1 = rotation by in_dirs |
| in_x | input | W | First element, signed |
| in_y | input | W | Second element, signed |
| in_dirs | input | ITER+2 | Direction word replayed in rotation mode |
| out_valid | output | 1 | Output pair is present this cycle |
| out_x | output | W+1 | First result, signed |
| out_y | output | W+1 | Second result, signed |
| out_dirs | output | ITER+2 | Direction word produced (vectoring) or passed through (rotation) |

## Verification
Every result is due exactly ITER+2 cycles after its pair is accepted. That count is one register for the pre-rotation, ITER registers for the micro-rotations and one for the gain stage. The bench stamps each accepted input with the cycle counter and each captured output with the counter value one half-cycle after the edge that registered it, and requires the difference to equal ITER+2. Outputs are matched to inputs strictly by order, so a lost, duplicated or early result shows up as a count or latency mismatch. The rotation pass reuses the direction words captured in the vectoring pass for the same index.

// File: rtl/cordic_givens.sv
`timescale 1ns/1ps
module cordic_givens #(
  parameter int W     = 16,
  parameter int ITER  = 12,
  parameter int GUARD = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic                in_rotate,
  input  logic signed [W-1:0] in_x,
  input  logic signed [W-1:0] in_y,
  input  logic [ITER+1:0]     in_dirs,
  output logic                out_valid,
  output logic signed [W:0]   out_x,
  output logic signed [W:0]   out_y,
  output logic [ITER+1:0]     out_dirs
);

  localparam int IW  = W + 2 + GUARD;
  localparam int DW  = ITER + 2;
  localparam int TOL = (1 << (W - ITER + 1)) + 4;

  logic signed [IW-1:0] px [0:ITER];
  logic signed [IW-1:0] py [0:ITER];
  logic [DW-1:0]        pd [0:ITER];
  logic [ITER:0]        pv, pm;

  logic signed [IW-1:0] nx [0:ITER-1];
  logic signed [IW-1:0] ny [0:ITER-1];
  logic [DW-1:0]        nd [0:ITER-1];
  logic                 om;

  // quarter-turn pre-rotation
  logic signed [IW-1:0] ex, ey, x0, y0;
  logic                 pre_en, pre_neg;
  logic [DW-1:0]        d0;

  assign ex      = IW'(in_x) <<< GUARD;
  assign ey      = IW'(in_y) <<< GUARD;
  assign pre_en  = in_rotate ? in_dirs[0] : in_x[W-1];
  assign pre_neg = in_rotate ? in_dirs[1] : in_y[W-1];
  assign x0      = !pre_en ? ex : (pre_neg ? -ey : ey);
  assign y0      = !pre_en ? ey : (pre_neg ? ex : -ex);
  assign d0      = in_rotate ? in_dirs : {{ITER{1'b0}}, pre_neg, pre_en};

  // micro-rotations: vectoring decides, rotation replays the stored bit
  always_comb begin
    for (int k = 0; k < ITER; k++) begin
      logic up;
      up    = pm[k] ? pd[k][2+k] : !py[k][IW-1];
      nx[k] = up ? px[k] + (py[k] >>> k) : px[k] - (py[k] >>> k);
      ny[k] = up ? py[k] - (px[k] >>> k) : py[k] + (px[k] >>> k);
      nd[k] = pd[k];
      nd[k][2+k] = up;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pv        <= '0;
      out_valid <= 1'b0;
    end else begin
      pv        <= {pv[ITER-1:0], in_valid};
      out_valid <= pv[ITER];
    end
  end

  always_ff @(posedge clk) begin
    px[0] <= x0;
    py[0] <= y0;
    pd[0] <= d0;
    pm    <= {pm[ITER-1:0], in_rotate};
    for (int k = 0; k < ITER; k++) begin
      px[k+1] <= nx[k];
      py[k+1] <= ny[k];
      pd[k+1] <= nd[k];
    end
  end

  // gain correction ~0.607239, then round off guard bits
  function automatic logic signed [W:0] fin(input logic signed [IW-1:0] v);
    logic signed [IW-1:0] s;
    s = (v >>> 1) + (v >>> 3) - (v >>> 6) - (v >>> 9) - (v >>> 12) + (v >>> 14);
    s = s + IW'(1 << (GUARD - 1));
    return s[GUARD +: W+1];
  endfunction

  always_ff @(posedge clk) begin
    out_x    <= fin(px[ITER]);
    out_y    <= fin(py[ITER]);
    out_dirs <= pd[ITER];
    om       <= pm[ITER];
  end

  // R1
  reset_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> !out_valid);

  // R5
  pre_half_plane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pv[0] && !pm[0]) |-> !px[0][IW-1]);

  // R3
  vec_mag_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !om) |-> !out_x[W]);

  // R4
  vec_residual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !om) |-> (out_y <= TOL && out_y >= -TOL));

endmodule

// File: tb/test_cordic_givens.sv
`timescale 1ns/1ps
module test_cordic_givens;
  localparam int W = 16, ITER = 12, DW = ITER + 2, LAT = ITER + 2, N = 81;
  localparam int TOL = (1 << (W - ITER + 1)) + 4;

  logic clk = 0, rst_n = 0, in_valid = 0, in_rotate = 0;
  logic signed [W-1:0] in_x = '0, in_y = '0;
  logic [DW-1:0] in_dirs = '0;
  logic out_valid;
  logic signed [W:0] out_x, out_y;
  logic [DW-1:0] out_dirs;

  cordic_givens #(.W(W), .ITER(ITER), .GUARD(4)) i_cordic_givens (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_rotate(in_rotate),
    .in_x(in_x), .in_y(in_y), .in_dirs(in_dirs),
    .out_valid(out_valid), .out_x(out_x), .out_y(out_y), .out_dirs(out_dirs));

  always #2 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0, ic = 0, oc = 0;
  int ax[N], ay[N], cx[N], cy[N], vx[N], vy[N];
  int rx[N], ry[N], rcyc[N], icyc[N];
  logic [DW-1:0] vd[N], rd[N];
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (oc < N) begin
        rx[oc] = int'(out_x);
        ry[oc] = int'(out_y);
        rd[oc] = out_dirs;
        rcyc[oc] = cyc;
      end
      oc++;
    end
  end

  function automatic real fabs(input real v);
    return (v < 0.0) ? -v : v;
  endfunction

  task automatic check(input bit ok, input string req, input real act, input real exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0.3f expected %0.3f", req, act, exp);
    end
  endtask

  task automatic stream(input bit rot, input bit alt);
    ic = 0;
    oc = 0;
    for (int k = 0; k < N; k++) begin
      @(negedge clk);
      if (k % 7 == 3) begin
        in_valid = 0;
        @(negedge clk);
      end
      in_valid  = 1;
      in_rotate = rot;
      in_x      = rot ? W'(cx[k]) : W'(ax[k]);
      in_y      = rot ? W'(cy[k]) : W'(ay[k]);
      in_dirs   = rot ? vd[k] : (alt ? '1 : '0);
      icyc[ic]  = cyc;
      ic++;
    end
    @(negedge clk);
    in_valid = 0;
    repeat (LAT + 4) @(negedge clk);
    check(oc == N, "R2 output count", oc, N);
    for (int k = 0; k < N; k++)
      check(rcyc[k] - icyc[k] == LAT, "R9 latency", rcyc[k] - icyc[k], LAT);
  endtask

  initial begin
    for (int i = 0; i < 9; i++)
      for (int j = 0; j < 9; j++) begin
        ax[i*9+j] = -20000 + 5037 * i;
        ay[i*9+j] = -20000 + 5037 * j;
        cx[i*9+j] = -20000 + 5037 * ((i + 3) % 9);
        cy[i*9+j] = -20000 + 5037 * ((j + 5) % 9);
      end

    repeat (3) @(negedge clk);
    check(out_valid == 0, "R1 in reset", out_valid, 0);
    rst_n = 1;
    @(negedge clk);
    check(out_valid == 0, "R1 after release", out_valid, 0);
    repeat (4) @(negedge clk);

    // vectoring, in_dirs = 0
    stream(0, 0);
    for (int k = 0; k < N; k++) begin
      real r;
      r = $sqrt(real'(ax[k]) * ax[k] + real'(ay[k]) * ay[k]);
      vx[k] = rx[k]; vy[k] = ry[k]; vd[k] = rd[k];
      check(rx[k] >= 0 && fabs(rx[k] - r) <= 3.0, "R3 magnitude", rx[k], r);
      check(ry[k] <= TOL && ry[k] >= -TOL, "R4 residual y", ry[k], 0.0);
      if (ax[k] < 0)
        check(fabs(rx[k] - r) <= 3.0 && ry[k] <= TOL && ry[k] >= -TOL,
              "R5 left half-plane", rx[k], r);
      check(rd[k][0] == (ax[k] < 0), "R6 pre-rotation flag", rd[k][0], ax[k] < 0);
      check(rd[k][1] == (ay[k] < 0), "R6 pre-rotation sign", rd[k][1], ay[k] < 0);
    end

    // vectoring again with in_dirs all ones: must match exactly
    stream(0, 1);
    for (int k = 0; k < N; k++)
      check(rx[k] == vx[k] && ry[k] == vy[k] && rd[k] == vd[k],
            "R10 in_dirs ignored", rx[k] + ry[k], vx[k] + vy[k]);

    // rotation of a second pair with the captured directions
    stream(1, 0);
    for (int k = 0; k < N; k++) begin
      real r, ex, ey;
      r  = $sqrt(real'(ax[k]) * ax[k] + real'(ay[k]) * ay[k]);
      ex = (real'(cx[k]) * ax[k] + real'(cy[k]) * ay[k]) / r;
      ey = (real'(cy[k]) * ax[k] - real'(cx[k]) * ay[k]) / r;
      check(fabs(rx[k] - ex) <= 24.0, "R7 rotated x", rx[k], ex);
      check(fabs(ry[k] - ey) <= 24.0, "R7 rotated y", ry[k], ey);
      check(rd[k] == vd[k], "R8 dirs pass-through", rd[k], vd[k]);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule